// File: doc/BRIEF.md
# Oversampled Serial Receiver with Noise Detection

This block receives asynchronous serial characters on a single line. A clock enable pulses at sixteen times the bit rate; each pulse takes one sample of the synchronised line. The receiver looks for a falling edge and confirms it with a vote over three early samples. It then recovers every bit with a 2-of-3 vote in the middle of the bit time and realigns its bit timing on every qualifying falling edge it sees during the character. The frame is one start bit, eight data bits sent least significant bit first, and one stop bit.

Completed characters go into one holding register with four flags: data-full, overrun, noise and framing error. The host reads these flags as level outputs. To release the register, the host pulses a status-read strobe while a flag is set and then a data-read strobe. Bit-rate generation, parity and the transmitter are outside the block.

Top module: `uart_os_rx`

## Requirements
- R1: A falling edge exists only on a tick whose sample is 0 and whose three preceding tick samples were all 1; a 0 that follows fewer than three 1 samples does not start a character.
- R2: The edge sample is bit-time position 1 of the start bit. Each of the eight data bits takes the 2-of-3 majority of its samples at positions 8, 9 and 10. The first data bit received is bit 0 of `data_o`.
- R3: The start bit is accepted only if at least two of its samples at positions 3, 5 and 7 are 0. Otherwise nothing is received and the receiver resumes hunting for an edge.
- R4: An accepted start bit counts as 0 even when its samples at positions 8, 9 and 10 are 1.
- R5: `noise_o` is loaded with the character and is 1 if any of these samples disagrees with its bit's value: positions 3, 5, 7, 8, 9 and 10 of the start bit (value 0), or positions 8, 9 and 10 of a data or stop bit (their majority).
- R6: The character is transferred on the tick of stop-bit position 10. If `full_o` is 0, `data_o` loads, `full_o` becomes 1, and the receiver returns to edge hunting.
- R7: If `full_o` is already 1 at transfer, `ovr_o` becomes 1 and `data_o`, `noise_o` and `ferr_o` keep their values.
- R8: A stop bit whose majority is 0 sets `ferr_o`, and the character is still transferred.
- R9: The flags clear only through two steps: a `rd_stat_i` pulse while `full_o` or `ovr_o` is 1, then a later `rd_data_i` pulse. The second step clears all four flags. A `rd_data_i` pulse without the first step changes nothing.
- R10: During data and stop bits, a falling edge at position 1–7 restarts the current bit at position 1. A falling edge at position 11–16 starts the next bit at position 1. A falling edge at positions 8–10 is ignored.
- R11: After reset all four flags and `data_o` are 0, and the receiver is hunting for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16_i | input | 1 | Sample enable at 16x the bit rate |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| rd_stat_i | input | 1 | Status-read strobe (first step of flag release) |
| rd_data_i | input | 1 | Data-read strobe (second step of flag release) |
| data_o | output | 8 | Receive holding register |
| full_o | output | 1 | Holding register contains an unread character |
| ovr_o | output | 1 | A character was lost because the register was full |
| noise_o | output | 1 | The held character had a disagreeing sample |
| ferr_o | output | 1 | The held character had a 0 stop bit |

## Verification
The bench sends a start pulse whose votes at positions 3, 5 and 7 fail. A receiver that trusted the edge alone would produce a character there. It also sends a start bit that goes high from position 8, which a receiver that re-voted the start bit would reject. It sends a frame at a bit time of 17 samples with alternating data. Without edge resynchronisation, that frame gives noise on bit 7 and a false framing error on the stop bit. It also drives a low line after a framing error that rises for only two samples and falls again; a detector that ignored the three-sample history would take a second character there and raise overrun. Data reads without a prior status read, and back-to-back characters with no read, check that flags survive and that an overrun keeps the first character.

// File: rtl/uart_os_pkg.sv
package uart_os_pkg;

    localparam int OVS     = 16;
    localparam int DATA_W  = 8;
    localparam int RTW     = $clog2(OVS + 1);

    localparam logic [RTW-1:0] POS_FIRST = RTW'(1);
    localparam logic [RTW-1:0] POS_LAST  = RTW'(OVS);
    localparam logic [RTW-1:0] POS_QA    = RTW'(3);
    localparam logic [RTW-1:0] POS_QB    = RTW'(5);
    localparam logic [RTW-1:0] POS_QC    = RTW'(7);
    localparam logic [RTW-1:0] POS_VA    = RTW'(8);
    localparam logic [RTW-1:0] POS_VB    = RTW'(9);
    localparam logic [RTW-1:0] POS_VC    = RTW'(10);

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              noise;
        logic              ferr;
    } rx_char_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_front.sv
module rx_front #(
    parameter int SYNC_N = 2,
    parameter int HIST_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_i,
    output logic smp_o,
    output logic edge_o
);
    logic [SYNC_N-1:0] sync_q;
    logic [HIST_N-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], line_i};
            if (tick) hist_q <= {hist_q[HIST_N-2:0], sync_q[SYNC_N-1]};
        end
    end

    assign smp_o  = sync_q[SYNC_N-1];
    // a low sample after a full run of high samples
    assign edge_o = tick & ~smp_o & (&hist_q);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
    import uart_os_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     smp_i,
    input  logic     edge_i,
    output logic     xfer_o,
    output rx_char_t char_o
);
    localparam int              BITW     = $clog2(DATA_W + 2);
    localparam logic [BITW-1:0] STOP_IDX = BITW'(DATA_W + 1);

    rx_state_e         state_q;
    logic [RTW-1:0]    rt_q;
    logic [BITW-1:0]   idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [1:0]        v_q;
    logic [1:0]        zc_q;
    logic              nf_q;

    logic           wrap, rs_early, rs_late, adv;
    logic [RTW-1:0] cur, pos;
    logic           qual_pos, vote_pos, bit_val, bit_dis;
    logic [1:0]     zeros;

    always_comb begin
        wrap     = (rt_q == POS_LAST);
        cur      = wrap ? POS_FIRST : rt_q + 1'b1;
        rs_early = edge_i && (state_q == ST_BITS) && (cur <= POS_QC);
        rs_late  = edge_i && (state_q == ST_BITS) && (cur > POS_VC);
        pos      = (rs_early || rs_late) ? POS_FIRST : cur;
        adv      = wrap || rs_late;
        qual_pos = (pos == POS_QA) || (pos == POS_QB) || (pos == POS_QC);
        vote_pos = (pos == POS_VA) || (pos == POS_VB) || (pos == POS_VC);
        zeros    = zc_q + {1'b0, ~smp_i};
        bit_val  = maj3(v_q[0], v_q[1], smp_i);
        bit_dis  = !((v_q[0] == v_q[1]) && (v_q[1] == smp_i));
        xfer_o   = tick && (state_q == ST_BITS) && (idx_q == STOP_IDX) && (pos == POS_VC);
        char_o.data  = sh_q;
        char_o.noise = nf_q | bit_dis;
        char_o.ferr  = ~bit_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            rt_q    <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            v_q     <= '0;
            zc_q    <= '0;
            nf_q    <= 1'b0;
        end else if (tick) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (edge_i) begin
                        state_q <= ST_START;
                        rt_q    <= POS_FIRST;
                        idx_q   <= '0;
                        zc_q    <= '0;
                        nf_q    <= 1'b0;
                    end
                end
                ST_START: begin
                    rt_q <= pos;
                    if (qual_pos && !smp_i) zc_q <= zc_q + 1'b1;
                    if ((qual_pos || vote_pos) && smp_i) nf_q <= 1'b1;
                    if (pos == POS_QC && zeros < 2'd2) state_q <= ST_HUNT;
                    if (wrap) begin
                        state_q <= ST_BITS;
                        idx_q   <= BITW'(1);
                    end
                end
                ST_BITS: begin
                    rt_q <= pos;
                    if (adv) idx_q <= idx_q + 1'b1;
                    if (pos == POS_VA) v_q[0] <= smp_i;
                    if (pos == POS_VB) v_q[1] <= smp_i;
                    if (pos == POS_VC) begin
                        if (bit_dis) nf_q <= 1'b1;
                        if (idx_q == STOP_IDX) state_q <= ST_HUNT;
                        else sh_q <= {bit_val, sh_q[DATA_W-1:1]};
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // R3
    hunt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && state_q == ST_HUNT && !edge_i) |=> (state_q == ST_HUNT));

    // R6
    back_to_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_o |=> (state_q == ST_HUNT));
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import uart_os_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_i,
    input  rx_char_t          char_i,
    input  logic              rd_stat_i,
    input  logic              rd_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              noise_o,
    output logic              ferr_o
);
    logic [DATA_W-1:0] data_q;
    logic full_q, ovr_q, noise_q, ferr_q, arm_q;
    logic clr;

    assign clr = rd_data_i && arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            ferr_q  <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (rd_stat_i && (full_q || ovr_q)) arm_q <= 1'b1;
            if (rd_data_i) arm_q <= 1'b0;
            if (clr) begin
                full_q  <= 1'b0;
                ovr_q   <= 1'b0;
                noise_q <= 1'b0;
                ferr_q  <= 1'b0;
            end
            if (xfer_i) begin
                if (!full_q || clr) begin
                    data_q  <= char_i.data;
                    noise_q <= char_i.noise;
                    ferr_q  <= char_i.ferr;
                    full_q  <= 1'b1;
                end else begin
                    ovr_q <= 1'b1;
                end
            end
        end
    end

    assign data_o  = data_q;
    assign full_o  = full_q;
    assign ovr_o   = ovr_q;
    assign noise_o = noise_q;
    assign ferr_o  = ferr_q;

    // R6
    full_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && !full_q) |=> full_q);

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_i && full_q && !clr) |=> (ovr_q && $stable(data_q)));

    // R9
    no_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_i && !arm_q && !xfer_i) |=> $stable({full_q, ovr_q, noise_q, ferr_q}));
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16_i,
    input  logic              rxd_i,
    input  logic              rd_stat_i,
    input  logic              rd_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              noise_o,
    output logic              ferr_o
);
    logic     smp, edge_det, xfer;
    rx_char_t chr;

    rx_front #(.SYNC_N(SYNC_STAGES), .HIST_N(3)) u_front (
        .clk(clk), .rst(rst), .tick(tick16_i), .line_i(rxd_i),
        .smp_o(smp), .edge_o(edge_det)
    );

    rx_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick16_i), .smp_i(smp), .edge_i(edge_det),
        .xfer_o(xfer), .char_o(chr)
    );

    rx_hold u_hold (
        .clk(clk), .rst(rst), .xfer_i(xfer), .char_i(chr),
        .rd_stat_i(rd_stat_i), .rd_data_i(rd_data_i),
        .data_o(data_o), .full_o(full_o), .ovr_o(ovr_o),
        .noise_o(noise_o), .ferr_o(ferr_o)
    );
endmodule

// File: tb/sim_uart_os_rx.sv
module sim_uart_os_rx;
    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rxd = 1'b1, rds = 1'b0, rdd = 1'b0;
    logic [7:0] data;
    logic full, ovr, noise, ferr;

    always #2 clk = ~clk;

    uart_os_rx u0 (
        .clk(clk), .rst(rst), .tick16_i(tick), .rxd_i(rxd),
        .rd_stat_i(rds), .rd_data_i(rdd),
        .data_o(data), .full_o(full), .ovr_o(ovr), .noise_o(noise), .ferr_o(ferr)
    );

    int n_chk = 0, n_fail = 0;
    bit cmp_en = 0;

    // line stream: one entry per sample slot of four clocks
    bit         q_ln[$];
    int         q_ev[$];
    int         q_rd[$];
    logic [7:0] ev_d[$];
    bit         ev_nf[$];
    bit         ev_fe[$];

    // behavioural flag model
    logic [7:0] m_d = 8'h00;
    bit m_full = 0, m_ovr = 0, m_nf = 0, m_fe = 0, m_arm = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_slot(input bit v, input int rd);
        q_ln.push_back(v);
        q_ev.push_back(-1);
        q_rd.push_back(rd);
    endtask

    task automatic idle(input int n);
        repeat (n) push_slot(1'b1, 0);
    endtask

    task automatic frame(input logic [7:0] d, input int spb, output int base);
        base = q_ln.size();
        repeat (spb) push_slot(1'b0, 0);
        for (int b = 0; b < 8; b++) repeat (spb) push_slot(d[b], 0);
        repeat (spb) push_slot(1'b1, 0);
    endtask

    task automatic expect_ev(input int at, input logic [7:0] d, input bit nf, input bit fe);
        q_ev[at] = ev_d.size();
        ev_d.push_back(d);
        ev_nf.push_back(nf);
        ev_fe.push_back(fe);
    endtask

    task automatic rd_seq();
        push_slot(1'b1, 1);
        push_slot(1'b1, 2);
    endtask

    task automatic run();
        for (int s = 0; s < q_ln.size(); s++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                rxd  = q_ln[s];
                tick = (c == 3);
                rds  = (c == 1) && (q_rd[s] == 1);
                rdd  = (c == 1) && (q_rd[s] == 2);
                @(posedge clk);
                begin
                    bit clr;
                    clr = rdd && m_arm;
                    if (rds && (m_full || m_ovr)) m_arm = 1;
                    if (rdd) m_arm = 0;
                    if (clr) begin m_full = 0; m_ovr = 0; m_nf = 0; m_fe = 0; end
                    if (tick && q_ev[s] >= 0) begin
                        if (!m_full) begin
                            m_d = ev_d[q_ev[s]]; m_nf = ev_nf[q_ev[s]];
                            m_fe = ev_fe[q_ev[s]]; m_full = 1;
                        end else m_ovr = 1;
                    end
                end
            end
        end
        @(negedge clk);
        tick = 0; rds = 0; rdd = 0; rxd = 1'b1;
        q_ln.delete(); q_ev.delete(); q_rd.delete();
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2 data_o", data, m_d);
            chk("R6 full_o", full, m_full);
            chk("R7 ovr_o", ovr, m_ovr);
            chk("R5 noise_o", noise, m_nf);
            chk("R8 ferr_o", ferr, m_fe);
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int b;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 full", full, 0);
        chk("R11 ovr", ovr, 0);
        chk("R11 noise", noise, 0);
        chk("R11 ferr", ferr, 0);
        chk("R11 data", data, 0);
        cmp_en = 1;

        // R2 R6 clean character
        idle(8); frame(8'hA5, 16, b); expect_ev(b + 153, 8'hA5, 0, 0); idle(20);
        run();
        chk("R6 full after clean frame", full, 1);
        chk("R2 data clean frame", data, 8'hA5);
        rd_seq(); idle(2); run();
        chk("R9 full cleared by sequence", full, 0);

        // R5 noise: 0 at position 9 of a 1 bit, 1 at position 8 of a 0 bit
        idle(8); frame(8'h3C, 16, b);
        q_ln[b + 3*16 + 8] = 1'b0;
        q_ln[b + 2*16 + 7] = 1'b1;
        expect_ev(b + 153, 8'h3C, 1, 0); idle(20);
        run();
        chk("R5 noise set", noise, 1);
        chk("R2 data voted through noise", data, 8'h3C);
        push_slot(1'b1, 2); idle(2); run();
        chk("R9 data read alone keeps full", full, 1);
        rd_seq(); idle(2); run();
        chk("R9 noise cleared", noise, 0);

        // R3 false start: only one of positions 3,5,7 low
        idle(8); repeat (4) push_slot(1'b0, 0); idle(40);
        run();
        chk("R3 rejected start", full, 0);
        frame(8'h81, 16, b); expect_ev(b + 153, 8'h81, 0, 0); idle(20);
        run();
        chk("R3 hunt resumes after reject", data, 8'h81);
        rd_seq(); idle(2); run();

        // R4 start bit high from position 8
        idle(8); frame(8'h12, 16, b);
        for (int k = 7; k < 16; k++) q_ln[b + k] = 1'b1;
        expect_ev(b + 153, 8'h12, 1, 0); idle(20);
        run();
        chk("R4 start accepted", full, 1);
        chk("R4 data", data, 8'h12);
        chk("R4 noise from start", noise, 1);
        rd_seq(); idle(2); run();

        // R7 overrun
        idle(8); frame(8'h0F, 16, b); expect_ev(b + 153, 8'h0F, 0, 0); idle(20);
        frame(8'hF0, 16, b); expect_ev(b + 153, 8'hF0, 0, 0); idle(20);
        run();
        chk("R7 overrun set", ovr, 1);
        chk("R7 first char kept", data, 8'h0F);
        rd_seq(); idle(2); run();
        chk("R9 overrun cleared", ovr, 0);

        // R8 framing, then R1 low line with a two-sample high pulse
        idle(8); frame(8'h99, 16, b);
        for (int k = 144; k < 160; k++) q_ln[b + k] = 1'b0;
        expect_ev(b + 153, 8'h99, 0, 1);
        repeat (20) push_slot(1'b0, 0);
        push_slot(1'b1, 0); push_slot(1'b1, 0);
        repeat (170) push_slot(1'b0, 0);
        idle(30);
        run();
        chk("R8 framing flag", ferr, 1);
        chk("R8 char still transferred", data, 8'h99);
        chk("R1 no edge after two highs", ovr, 0);
        rd_seq(); idle(2); run();

        // R10 slow bit time of 17 samples, alternating data
        idle(8); frame(8'h55, 17, b); expect_ev(b + 161, 8'h55, 0, 0); idle(20);
        run();
        chk("R10 data with resync", data, 8'h55);
        chk("R10 no noise with resync", noise, 0);
        chk("R10 no framing with resync", ferr, 0);

        cmp_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule